// File: doc/BRIEF.md
# Shift-Cell Bit Stack with Time-Shared Command Pin

This block is a last-in first-out store, one bit wide and `DEPTH` entries deep. It is built from a chain of shift cells rather than from an addressed memory. One stack cycle spans two edges of a fast clock. The strobe `ph_late` marks the second of those two edges. A single command pin carries two command bits, one after the other. The first bit is taken on the late edge of the cycle before. The second bit is taken on the early edge of the current cycle. As a result, the command reaches the block half a cycle ahead of the data.

On the early edge, the two bits are decoded into one of the named commands `OP_PUSH`, `OP_POP` or `OP_HOLD`. The cells then shift down on a push and up on a pop, or they keep their contents. The block keeps no depth count, so a push or pop always shifts whatever the cells hold. Each cell stores its bit inverted. The output re-inverts the top bit, so the external data is true polarity.

The command decoder tracks one piece of state, the latched first bit. Its transitions are "capture" on a late edge and "decode" on an early edge, which drives one of the three commands. A sampled bit pair of (1,1) also decodes to `OP_HOLD`.

Top module: `stk_shift_stack`

## Requirements
- R1: The first command bit is sampled from `cmd_pin` on a clock edge with `ph_late`=1, and the second on the next edge with `ph_late`=0. The pair (first,second) = (1,0) is push, (0,1) is pop and (0,0) is hold.
- R2: Cells and `dout` change only on edges with `ph_late`=0, and `din` is sampled only on those edges. A `din` value presented on a late edge has no effect.
- R3: A push loads `din` into location 1 (top) and moves each location i to i+1. The old bottom value is discarded.
- R4: A pop moves each location i+1 to location i, and `dout` takes the top value from before the pop, one clock after the decode edge.
- R5: After a pop, the bottom location holds 0.
- R6: On hold, every location and `dout` keep their values.
- R7: The pair (1,1) acts as hold.
- R8: No depth is tracked. Pops from an empty stack return the 0 fill, and pushes beyond `DEPTH` drop the oldest entry.
- R9: `dout` keeps the last popped value through non-pop cycles.
- R10: A synchronous reset makes every location 0, clears the latched first bit, and sets `dout` to 0.
- R11: Cells hold the bit inverted, while `din` and `dout` are true polarity. A pushed 1 pops as 1.
- R12: The behaviour above holds for `DEPTH` = 4 and `DEPTH` = 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, two edges per stack cycle |
| rst | input | 1 | Synchronous active-high reset |
| ph_late | input | 1 | High on the second (late) edge of a stack cycle |
| cmd_pin | input | 1 | Time-shared command bit |
| din | input | 1 | Data bit to push |
| dout | output | 1 | Last popped data bit |

## Verification
The properties assume that `ph_late` alternates on every clock: each early edge follows a late edge that supplied the first command bit. They also assume that `cmd_pin` and `din` are settled before each edge. The checker keeps its own copy of the first bit, sampled from the pin on late edges, and compares each decoded effect against it. The bench drives every input on the falling edge, toggles `ph_late` once per clock, and drives the inverse of the data on late edges so that any late sampling of `din` would show.

// File: rtl/stk_shift_pkg.sv
package stk_shift_pkg;
    typedef enum logic [1:0] {
        OP_HOLD = 2'd0,
        OP_PUSH = 2'd1,
        OP_POP  = 2'd2
    } stk_op_e;
endpackage

// File: rtl/stk_cmd_decode.sv
module stk_cmd_decode
    import stk_shift_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    ph_late,
    input  logic    cmd_pin,
    output stk_op_e op
);
    logic first_q;

    // State register: capture the first command bit on the late edge.
    always_ff @(posedge clk) begin
        if (rst)
            first_q <= 1'b0;
        else if (ph_late)
            first_q <= cmd_pin;
    end

    // Output process: decode on the early edge only.
    always_comb begin
        op = OP_HOLD;
        if (!ph_late) begin
            unique case ({first_q, cmd_pin})
                2'b10:   op = OP_PUSH;
                2'b01:   op = OP_POP;
                default: op = OP_HOLD;
            endcase
        end
    end
endmodule

// File: rtl/stk_cell.sv
module stk_cell
    import stk_shift_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  stk_op_e op,
    input  logic    above_n,
    input  logic    below_n,
    output logic    val_n
);
    always_ff @(posedge clk) begin
        if (rst)
            val_n <= 1'b1;
        else begin
            unique case (op)
                OP_PUSH: val_n <= above_n;
                OP_POP:  val_n <= below_n;
                default: val_n <= val_n;
            endcase
        end
    end
endmodule

// File: rtl/stk_shift_stack.sv
module stk_shift_stack
    import stk_shift_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic ph_late,
    input  logic cmd_pin,
    input  logic din,
    output logic dout
);
    localparam int LAST = DEPTH - 1;

    stk_op_e            op;
    logic [DEPTH-1:0]   cell_n;

    stk_cmd_decode u_dec (
        .clk     (clk),
        .rst     (rst),
        .ph_late (ph_late),
        .cmd_pin (cmd_pin),
        .op      (op)
    );

    for (genvar i = 0; i < DEPTH; i++) begin : g_cell
        logic above_n;
        logic below_n;
        if (i == 0) begin : g_top
            assign above_n = ~din;
        end else begin : g_mid_a
            assign above_n = cell_n[i-1];
        end
        if (i == LAST) begin : g_bot
            assign below_n = 1'b1;
        end else begin : g_mid_b
            assign below_n = cell_n[i+1];
        end
        stk_cell u_cell (
            .clk     (clk),
            .rst     (rst),
            .op      (op),
            .above_n (above_n),
            .below_n (below_n),
            .val_n   (cell_n[i])
        );
    end

    always_ff @(posedge clk) begin
        if (rst)
            dout <= 1'b0;
        else if (op == OP_POP)
            dout <= ~cell_n[0];
    end
endmodule

// File: rtl/stk_shift_checker.sv
module stk_shift_checker #(
    parameter int DEPTH = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             ph_late,
    input logic             cmd_pin,
    input logic             din,
    input logic             dout,
    input logic [DEPTH-1:0] cell_n
);
    logic sh_first;
    always_ff @(posedge clk) begin
        if (rst)
            sh_first <= 1'b0;
        else if (ph_late)
            sh_first <= cmd_pin;
    end

    logic early, is_push, is_pop, is_idle, is_both;
    assign early   = !ph_late;
    assign is_push = early && sh_first && !cmd_pin;
    assign is_pop  = early && !sh_first && cmd_pin;
    assign is_both = early && sh_first && cmd_pin;
    assign is_idle = early && !sh_first && !cmd_pin;

    p_late_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        ph_late |=> ($stable(cell_n) && $stable(dout)));

    p_push_top_r3: assert property (@(posedge clk) disable iff (rst)
        is_push |=> (cell_n[0] == ~$past(din)));

    p_push_shift_r3: assert property (@(posedge clk) disable iff (rst)
        is_push |=> (cell_n[DEPTH-1:1] == $past(cell_n[DEPTH-2:0])));

    p_pop_out_r4: assert property (@(posedge clk) disable iff (rst)
        is_pop |=> (dout == ~$past(cell_n[0])));

    p_pop_shift_r4: assert property (@(posedge clk) disable iff (rst)
        is_pop |=> (cell_n[DEPTH-2:0] == $past(cell_n[DEPTH-1:1])));

    p_pop_fill_r5: assert property (@(posedge clk) disable iff (rst)
        is_pop |=> cell_n[DEPTH-1]);

    p_hold_keep_r6: assert property (@(posedge clk) disable iff (rst)
        is_idle |=> ($stable(cell_n) && $stable(dout)));

    p_both_hold_r7: assert property (@(posedge clk) disable iff (rst)
        is_both |=> ($stable(cell_n) && $stable(dout)));

    p_reset_clear_r10: assert property (@(posedge clk)
        rst |=> (dout == 1'b0 && (&cell_n)));
endmodule

bind stk_shift_stack stk_shift_checker #(.DEPTH(DEPTH)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .ph_late (ph_late),
    .cmd_pin (cmd_pin),
    .din     (din),
    .dout    (dout),
    .cell_n  (cell_n)
);

// File: tb/test_stk_shift_stack.sv
`timescale 1ns/1ps
module test_stk_shift_stack;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ph_late = 1'b0;
    logic cmd_pin = 1'b0;
    logic din = 1'b0;
    logic dout4, dout16;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    logic m4  [4];
    logic m16 [16];
    logic last4, last16;

    always #2 clk = ~clk;

    stk_shift_stack #(.DEPTH(4)) i_stk_shift_stack (
        .clk(clk), .rst(rst), .ph_late(ph_late), .cmd_pin(cmd_pin),
        .din(din), .dout(dout4));

    stk_shift_stack #(.DEPTH(16)) i_stk_shift_stack_d16 (
        .clk(clk), .rst(rst), .ph_late(ph_late), .cmd_pin(cmd_pin),
        .din(din), .dout(dout16));

    task automatic chk(input logic act, input logic exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int i = 0; i < 4; i++) m4[i] = 1'b0;
        for (int i = 0; i < 16; i++) m16[i] = 1'b0;
        last4 = 1'b0;
        last16 = 1'b0;
    endtask

    // One stack cycle: late edge carries the first bit, early edge the second.
    task automatic cyc(input logic b1, input logic b2, input logic d, input string tag);
        @(negedge clk);
        ph_late = 1'b1; cmd_pin = b1; din = ~d;
        @(negedge clk);
        ph_late = 1'b0; cmd_pin = b2; din = d;
        @(posedge clk);
        #1;
        if (b1 && !b2) begin
            for (int i = 3; i > 0; i--) m4[i] = m4[i-1];
            for (int i = 15; i > 0; i--) m16[i] = m16[i-1];
            m4[0] = d; m16[0] = d;
        end else if (!b1 && b2) begin
            last4 = m4[0]; last16 = m16[0];
            for (int i = 0; i < 3; i++) m4[i] = m4[i+1];
            for (int i = 0; i < 15; i++) m16[i] = m16[i+1];
            m4[3] = 1'b0; m16[15] = 1'b0;
        end
        chk(dout4, last4, {tag, " d4"});
        chk(dout16, last16, {tag, " d16"});
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; ph_late = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        model_clear();
    endtask

    task automatic drain(input string tag);
        for (int i = 0; i < 17; i++) cyc(1'b0, 1'b1, 1'b0, tag);
    endtask

    task automatic t_reset();
        do_reset();
        chk(dout4, 1'b0, "R10 reset d4");
        chk(dout16, 1'b0, "R10 reset d16");
        drain("R10 cells cleared");
    endtask

    task automatic t_lifo();
        cyc(1'b1, 1'b0, 1'b1, "R3 push");
        cyc(1'b1, 1'b0, 1'b0, "R3 push");
        cyc(1'b1, 1'b0, 1'b1, "R11 push");
        cyc(1'b1, 1'b0, 1'b1, "R1 push");
        for (int i = 0; i < 4; i++) cyc(1'b0, 1'b1, 1'b0, "R4 pop order");
        drain("R12 drain");
    endtask

    task automatic t_overflow();
        for (int i = 0; i < 18; i++) cyc(1'b1, 1'b0, logic'(i % 3 != 1), "R8 overfill");
        drain("R8 overflow pop R5");
    endtask

    task automatic t_hold();
        cyc(1'b1, 1'b0, 1'b1, "R3 push");
        cyc(1'b1, 1'b0, 1'b0, "R3 push");
        cyc(1'b0, 1'b0, 1'b1, "R6 hold");
        cyc(1'b0, 1'b1, 1'b0, "R4 pop");
        cyc(1'b0, 1'b0, 1'b1, "R9 hold keeps dout");
        cyc(1'b0, 1'b0, 1'b0, "R9 hold keeps dout");
        cyc(1'b0, 1'b1, 1'b0, "R6 pop after hold");
        cyc(1'b1, 1'b0, 1'b1, "R9 push keeps dout");
        drain("R6 drain");
    endtask

    task automatic t_illegal();
        cyc(1'b1, 1'b0, 1'b1, "R7 push");
        cyc(1'b1, 1'b1, 1'b0, "R7 both bits");
        cyc(1'b1, 1'b1, 1'b1, "R7 both bits");
        drain("R7 drain");
    endtask

    task automatic t_phase();
        // Pin at 1 on late edge and 0 on early edge: push, not pop.
        cyc(1'b1, 1'b0, 1'b0, "R1 push zero");
        cyc(1'b1, 1'b0, 1'b1, "R2 late din ignored");
        cyc(1'b0, 1'b1, 1'b0, "R1 pop");
        cyc(1'b0, 1'b1, 1'b0, "R1 pop");
        cyc(1'b0, 1'b1, 1'b0, "R5 empty pop");
    endtask

    task automatic t_reset_full();
        for (int i = 0; i < 16; i++) cyc(1'b1, 1'b0, 1'b1, "R10 fill");
        cyc(1'b0, 1'b1, 1'b0, "R10 pop before reset");
        do_reset();
        chk(dout4, 1'b0, "R10 dout after reset d4");
        chk(dout16, 1'b0, "R10 dout after reset d16");
        drain("R10 pop after reset");
    endtask

    initial begin
        model_clear();
        t_reset();
        t_lifo();
        t_overflow();
        t_hold();
        t_illegal();
        t_phase();
        t_reset_full();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #200000;
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule